// File: doc/BRIEF.md
# Float32 Reciprocal Square-Root Approximator

This block takes one IEEE-754 single-precision operand per cycle and produces an approximation of 1/sqrt(x), also in single precision. It sits as a pipelined arithmetic helper: a producer offers an operand with a valid bit and a flush-subnormals control bit. The result emerges with its own valid flag a fixed number of cycles later. The block never back-pressures, so its ready output is permanently high.

The operand is normalised to a mantissa in [1,2) and an unbiased exponent. An odd exponent is folded into the mantissa, which then lies in [1,4), and the result exponent becomes minus half the remaining even exponent. A seed for the mantissa comes from a small table addressed by the exponent parity and the leading fraction bits. The table is computed when the design is elaborated. One Newton-Raphson step in fixed point sharpens the seed. Zeros, infinities, negative operands, NaNs and subnormals bypass the arithmetic through a fixed special-value path. The block has no rounding mode input and produces no exception flags.

Top module: `rsqrt_approx`

## Requirements
- R1: For every positive normal finite operand, the result is a positive normal number whose relative error against the exact 1/sqrt(x) is strictly below 2^-14.
- R2: An operand equal to 2^(-2n), for any integer n (including subnormal operands such as 0x00000002), returns exactly 2^n.
- R3: An operand of +0 (0x00000000) returns +infinity (0x7F800000). An operand of -0 (0x80000000) returns -infinity (0xFF800000).
- R4: An operand of +infinity (0x7F800000) returns +0 (0x00000000).
- R5: Any operand below zero that is not a NaN and not a zero returns the default quiet NaN 0xFFC00000. This includes -infinity, and negative subnormals when flushing is off.
- R6: A NaN operand is returned with fraction bit 22 forced to 1 and all other bits unchanged. A signalling NaN is thereby quieted, and a quiet NaN passes through unchanged.
- R7: With in_daz low, a positive subnormal operand is normalised and approximated to the R1 bound, with a normal result (exponent field neither 0 nor 255). With in_daz high, any subnormal operand is treated as a zero of the same sign, as in R3.
- R8: in_ready is always 1. Every accepted operand yields exactly one result, with out_valid high exactly 3 cycles after acceptance. Results come out in acceptance order at up to one per cycle, and no result appears without an accepted operand.
- R9: A synchronous active-high rst clears all pipeline valid bits, so out_valid is low in the cycle after any reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered this cycle |
| in_ready | output | 1 | Always high; operand accepted whenever in_valid is high |
| in_data | input | 32 | Single-precision operand |
| in_daz | input | 1 | Treat subnormal operands as zero when high |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Single-precision approximate 1/sqrt(x) |

## Verification
The bench builds the block with the default parameters: a 7-bit fraction index (a 256-entry seed table over both exponent parities), a 12-bit seed fraction and a 28-bit correction fraction. This is the configuration whose seed error, squared by the Newton step, lands well inside 2^-14. With it, random normal and subnormal operands, values just above 1 and just below 4, the largest finite value and the smallest subnormal can all be checked against a real-valued reference. Every special value and each exact even power of two, from the subnormal range to the top of the normal range, is compared bit for bit. Back-to-back issue with occasional idle gaps exercises ordering and the three-cycle latency.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef longint unsigned u64_t;

    localparam logic [31:0] QNAN_DEFAULT = 32'hFFC0_0000;
    localparam logic [31:0] QUIET_BIT    = 32'h0040_0000;

    // Seed for table slot idx: floor(2^frac / sqrt(Mmid)), where Mmid is the
    // midpoint of the slot, scaled by 2 when the parity bit (above idx_bits) is set.
    function automatic u64_t seed_value(input int idx, input int idx_bits, input int frac);
        u64_t q;
        u64_t rhs;
        u64_t y;
        u64_t cand;
        int   parity;
        int   slot;
        parity = idx >> idx_bits;
        slot   = idx & ((1 << idx_bits) - 1);
        q      = u64_t'((1 << (idx_bits + 1)) + 2 * slot + 1) << parity;
        rhs    = u64_t'(1) << (2 * frac + idx_bits + 1);
        y      = 0;
        for (int b = frac; b >= 0; b--) begin
            cand = y | (u64_t'(1) << b);
            if (cand * cand * q <= rhs) y = cand;
        end
        return y;
    endfunction

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode #(
    parameter int IDX_BITS = 7
) (
    input  logic [31:0]         op,
    input  logic                daz,
    output logic                special,
    output logic [31:0]         spec_val,
    output logic                exact,
    output logic [24:0]         mant,
    output logic [IDX_BITS:0]   idx,
    output logic signed [9:0]   half
);
    logic                sgn;
    logic [7:0]          ex;
    logic [22:0]         fr;
    logic [4:0]          msb;
    logic [23:0]         m24;
    logic signed [9:0]   e;
    logic signed [9:0]   e_even;
    logic                odd;
    logic                is_nan;
    logic                is_zero;

    always_comb begin
        sgn = op[31];
        ex  = op[30:23];
        fr  = op[22:0];

        msb = 5'd0;
        for (int b = 0; b < 23; b++) begin
            if (fr[b]) msb = 5'(b);
        end

        if (ex != 8'd0) begin
            m24 = {1'b1, fr};
            e   = $signed({2'b00, ex}) - 10'sd127;
        end else begin
            m24 = 24'(fr) << (5'd23 - msb);
            e   = $signed({5'b00000, msb}) - 10'sd149;
        end

        odd    = e[0];
        e_even = e - $signed({9'd0, odd});
        half   = e_even >>> 1;
        mant   = odd ? {m24, 1'b0} : {1'b0, m24};
        idx    = {odd, m24[22 -: IDX_BITS]};
        exact  = !odd && (m24[22:0] == 23'd0);

        is_nan  = (ex == 8'hFF) && (fr != 23'd0);
        is_zero = (ex == 8'd0) && ((fr == 23'd0) || daz);

        special  = 1'b1;
        spec_val = 32'd0;
        if (is_nan) begin
            spec_val = op | rsq_pkg::QUIET_BIT;
        end else if (is_zero) begin
            spec_val = {sgn, 8'hFF, 23'd0};
        end else if (sgn) begin
            spec_val = rsq_pkg::QNAN_DEFAULT;
        end else if (ex == 8'hFF) begin
            spec_val = 32'd0;
        end else begin
            special = 1'b0;
        end
    end

endmodule

// File: rtl/rsq_newton.sv
module rsq_newton #(
    parameter int IDX_BITS  = 7,
    parameter int SEED_FRAC = 12,
    parameter int CORR_FRAC = 28
) (
    input  logic [IDX_BITS:0]    idx,
    input  logic [24:0]          mant,
    output logic [SEED_FRAC:0]   y0,
    output logic [CORR_FRAC+1:0] corr
);
    localparam int Y_W      = SEED_FRAC + 1;
    localparam int T_W      = CORR_FRAC + 2;
    localparam int ENTRIES  = 2 ** (IDX_BITS + 1);
    localparam int PROD_W   = 25 + 2 * Y_W;
    localparam int PROD_SHR = 23 + 2 * SEED_FRAC - CORR_FRAC;
    localparam logic [T_W-1:0] THREE = T_W'(3) << CORR_FRAC;

    logic [Y_W-1:0]    seed_rom [ENTRIES];
    logic [2*Y_W-1:0]  ysq;
    logic [PROD_W-1:0] prod;
    logic [T_W-1:0]    prod_t;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_seed
        localparam logic [Y_W-1:0] SEED_G = Y_W'(rsq_pkg::seed_value(g, IDX_BITS, SEED_FRAC));
        assign seed_rom[g] = SEED_G;
    end

    always_comb begin
        y0     = seed_rom[idx];
        ysq    = (2 * Y_W)'(y0) * (2 * Y_W)'(y0);
        prod   = PROD_W'(mant) * PROD_W'(ysq);
        prod_t = T_W'(prod >> PROD_SHR);
        corr   = THREE - prod_t;
    end

endmodule

// File: rtl/rsq_pack.sv
module rsq_pack #(
    parameter int SEED_FRAC = 12,
    parameter int CORR_FRAC = 28
) (
    input  logic [SEED_FRAC:0]   y0,
    input  logic [CORR_FRAC+1:0] corr,
    input  logic signed [9:0]    half,
    input  logic                 exact,
    input  logic                 special,
    input  logic [31:0]          spec_val,
    output logic [31:0]          result
);
    localparam int Y_W    = SEED_FRAC + 1;
    localparam int T_W    = CORR_FRAC + 2;
    localparam int P_W    = Y_W + T_W;
    localparam int Y1_SHR = SEED_FRAC + CORR_FRAC + 1 - 24;

    logic [P_W-1:0] y1_full;
    logic [24:0]    y1f;
    logic [22:0]    frac;
    logic [1:0]     adj;
    logic [7:0]     expo;

    always_comb begin
        y1_full = P_W'(y0) * P_W'(corr);
        y1f     = 25'(y1_full >> Y1_SHR);

        if (exact) begin
            frac = 23'd0;
            adj  = 2'd0;
        end else if (y1f[24]) begin
            frac = y1f[23:1];
            adj  = 2'd0;
        end else if (y1f[23]) begin
            frac = y1f[22:0];
            adj  = 2'd1;
        end else begin
            frac = {y1f[21:0], 1'b0};
            adj  = 2'd2;
        end

        expo   = 8'(10'sd127 - half - $signed({8'd0, adj}));
        result = special ? spec_val : {1'b0, expo, frac};
    end

endmodule

// File: rtl/rsqrt_approx.sv
module rsqrt_approx #(
    parameter int IDX_BITS  = 7,
    parameter int SEED_FRAC = 12,
    parameter int CORR_FRAC = 28
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_daz,
    output logic        out_valid,
    output logic [31:0] out_data
);
    localparam int Y_W = SEED_FRAC + 1;
    localparam int T_W = CORR_FRAC + 2;
    localparam int M_W = 25;

    typedef struct packed {
        logic                v1;
        logic                s1_special;
        logic [31:0]         s1_spec;
        logic                s1_exact;
        logic [M_W-1:0]      s1_mant;
        logic [IDX_BITS:0]   s1_idx;
        logic [9:0]          s1_half;
        logic                v2;
        logic                s2_special;
        logic [31:0]         s2_spec;
        logic                s2_exact;
        logic [9:0]          s2_half;
        logic [Y_W-1:0]      s2_y0;
        logic [T_W-1:0]      s2_corr;
        logic                v3;
        logic [31:0]         s3_res;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic                dec_special;
    logic [31:0]         dec_spec;
    logic                dec_exact;
    logic [M_W-1:0]      dec_mant;
    logic [IDX_BITS:0]   dec_idx;
    logic signed [9:0]   dec_half;
    logic [Y_W-1:0]      nr_y0;
    logic [T_W-1:0]      nr_corr;
    logic [31:0]         pk_res;

    rsq_decode #(.IDX_BITS(IDX_BITS)) u_decode (
        .op       (in_data),
        .daz      (in_daz),
        .special  (dec_special),
        .spec_val (dec_spec),
        .exact    (dec_exact),
        .mant     (dec_mant),
        .idx      (dec_idx),
        .half     (dec_half)
    );

    rsq_newton #(.IDX_BITS(IDX_BITS), .SEED_FRAC(SEED_FRAC), .CORR_FRAC(CORR_FRAC)) u_newton (
        .idx  (pipe_q.s1_idx),
        .mant (pipe_q.s1_mant),
        .y0   (nr_y0),
        .corr (nr_corr)
    );

    rsq_pack #(.SEED_FRAC(SEED_FRAC), .CORR_FRAC(CORR_FRAC)) u_pack (
        .y0       (pipe_q.s2_y0),
        .corr     (pipe_q.s2_corr),
        .half     ($signed(pipe_q.s2_half)),
        .exact    (pipe_q.s2_exact),
        .special  (pipe_q.s2_special),
        .spec_val (pipe_q.s2_spec),
        .result   (pk_res)
    );

    assign in_ready = 1'b1;

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: decode and normalise
        pipe_d.v1         = in_valid && in_ready;
        pipe_d.s1_special = dec_special;
        pipe_d.s1_spec    = dec_spec;
        pipe_d.s1_exact   = dec_exact;
        pipe_d.s1_mant    = dec_mant;
        pipe_d.s1_idx     = dec_idx;
        pipe_d.s1_half    = dec_half;
        // stage 2: seed lookup and correction factor
        pipe_d.v2         = pipe_q.v1;
        pipe_d.s2_special = pipe_q.s1_special;
        pipe_d.s2_spec    = pipe_q.s1_spec;
        pipe_d.s2_exact   = pipe_q.s1_exact;
        pipe_d.s2_half    = pipe_q.s1_half;
        pipe_d.s2_y0      = nr_y0;
        pipe_d.s2_corr    = nr_corr;
        // stage 3: refine, normalise, pack
        pipe_d.v3         = pipe_q.v2;
        pipe_d.s3_res     = pk_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q.v1 <= 1'b0;
            pipe_q.v2 <= 1'b0;
            pipe_q.v3 <= 1'b0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.v3;
    assign out_data  = pipe_q.s3_res;

endmodule

// File: rtl/rsqrt_approx_chk.sv
module rsqrt_approx_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_data,
    input logic        in_daz,
    input logic        out_valid,
    input logic [31:0] out_data
);
    logic [1:0] warm;
    logic       in_nan;
    logic       in_zeroish;
    logic       in_sub;

    always_ff @(posedge clk) begin
        if (rst) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assign in_nan     = (in_data[30:23] == 8'hFF) && (in_data[22:0] != 23'd0);
    assign in_sub     = (in_data[30:23] == 8'd0) && (in_data[22:0] != 23'd0);
    assign in_zeroish = (in_data[30:0] == 31'd0) || (in_sub && in_daz);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid && in_ready, 3)));

    assert_ready_R8: assert property (@(posedge clk) disable iff (rst) in_ready);

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_zero_inf_R3: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && in_zeroish, 3))
        |-> (out_data == {$past(in_data[31], 3), 8'hFF, 23'd0}));

    assert_pinf_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && (in_data == 32'h7F80_0000), 3))
        |-> (out_data == 32'd0));

    assert_negative_nan_R5: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && in_data[31] && !in_nan && !in_zeroish, 3))
        |-> (out_data == 32'hFFC0_0000));

    assert_nan_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && in_nan, 3))
        |-> (out_data == ($past(in_data, 3) | 32'h0040_0000)));

    assert_subnormal_normal_R7: assert property (@(posedge clk) disable iff (rst)
        ((warm == 2'd3) && $past(in_valid && !in_data[31] && in_sub && !in_daz, 3))
        |-> (!out_data[31] && (out_data[30:23] != 8'd0) && (out_data[30:23] != 8'hFF)));

endmodule

bind rsqrt_approx rsqrt_approx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_daz    (in_daz),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/rsqrt_approx_tb.sv
`timescale 1ns/1ps
module rsqrt_approx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = 32'd0;
    logic        in_daz = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    typedef struct {
        logic [31:0] din;
        bit          approx;
        logic [31:0] exp_bits;
        string       tag;
        int          cyc;
    } item_t;

    item_t sbq[$];
    item_t it;
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rsqrt_approx u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_daz    (in_daz),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic real f2r(input logic [31:0] b);
        real mag;
        int  e;
        e = int'(b[30:23]);
        if (e == 0) mag = real'(b[22:0]) * (2.0 ** (-149));
        else        mag = real'({1'b1, b[22:0]}) * (2.0 ** (e - 150));
        return b[31] ? -mag : mag;
    endfunction

    task automatic drive(input logic [31:0] d, input logic dz, input bit ap,
                         input logic [31:0] ex, input string tg);
        item_t n;
        in_valid   = 1'b1;
        in_data    = d;
        in_daz     = dz;
        n.din      = d;
        n.approx   = ap;
        n.exp_bits = ex;
        n.tag      = tg;
        n.cyc      = cyc;
        sbq.push_back(n);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && !done) begin
            n_vec++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected result got=%h expected no result", out_data);
            end else begin
                it = sbq.pop_front();
                if (cyc - it.cyc != 3) begin
                    n_bad++;
                    $display("FAIL R8 latency for in=%h got=%0d expected=3", it.din, cyc - it.cyc);
                end else if (!it.approx) begin
                    if (out_data !== it.exp_bits) begin
                        n_bad++;
                        $display("FAIL %s in=%h got=%h expected=%h", it.tag, it.din, out_data, it.exp_bits);
                    end
                end else begin
                    real refv;
                    real gotv;
                    real err;
                    refv = 1.0 / $sqrt(f2r(it.din));
                    gotv = f2r(out_data);
                    err  = (gotv > refv ? gotv - refv : refv - gotv) / refv;
                    if (out_data[31] || out_data[30:23] == 8'd0 || out_data[30:23] == 8'hFF
                        || !(err < 2.0 ** (-14))) begin
                        n_bad++;
                        $display("FAIL %s in=%h got=%h (rel err %g) expected normal result with rel err < %g",
                                 it.tag, it.din, out_data, err, 2.0 ** (-14));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL R8 watchdog expired got=hung expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R9: reset holds the output invalid
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 out_valid during reset got=%b expected=0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R9 after reset got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
        end

        // R3 / R4 / R5 / R6 specials
        drive(32'h0000_0000, 1'b0, 1'b0, 32'h7F80_0000, "R3");
        drive(32'h8000_0000, 1'b0, 1'b0, 32'hFF80_0000, "R3");
        drive(32'h7F80_0000, 1'b0, 1'b0, 32'h0000_0000, "R4");
        drive(32'hFF80_0000, 1'b0, 1'b0, 32'hFFC0_0000, "R5");
        drive(32'hBF80_0000, 1'b0, 1'b0, 32'hFFC0_0000, "R5");
        drive(32'h8000_0001, 1'b0, 1'b0, 32'hFFC0_0000, "R5");
        drive(32'h7FC0_0001, 1'b0, 1'b0, 32'h7FC0_0001, "R6");
        drive(32'h7F80_0001, 1'b0, 1'b0, 32'h7FC0_0001, "R6");
        drive(32'hFF80_0005, 1'b0, 1'b0, 32'hFFC0_0005, "R6");
        // R7 flush control
        drive(32'h0000_0001, 1'b1, 1'b0, 32'h7F80_0000, "R7");
        drive(32'h8040_0000, 1'b1, 1'b0, 32'hFF80_0000, "R7");
        drive(32'h0000_0001, 1'b0, 1'b1, 32'd0, "R7");
        drive(32'h007F_FFFF, 1'b0, 1'b1, 32'd0, "R7");
        idle(2);
        // R2 exact even powers of two
        drive(32'h3F80_0000, 1'b0, 1'b0, 32'h3F80_0000, "R2");
        drive(32'h4080_0000, 1'b0, 1'b0, 32'h3F00_0000, "R2");
        drive(32'h3E80_0000, 1'b0, 1'b0, 32'h4000_0000, "R2");
        drive(32'h0080_0000, 1'b0, 1'b0, 32'h5F00_0000, "R2");
        drive(32'h7E80_0000, 1'b0, 1'b0, 32'h2000_0000, "R2");
        drive(32'h0000_0002, 1'b0, 1'b0, 32'h6480_0000, "R2");
        // R1 boundary operands
        drive(32'h4000_0000, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h4040_0000, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h3F80_0001, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h3F7F_FFFF, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h407F_FFFF, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h7F7F_FFFF, 1'b0, 1'b1, 32'd0, "R1");
        drive(32'h0080_0001, 1'b0, 1'b1, 32'd0, "R1");
        idle(1);
        // R1 random normals, R7 random subnormals, with occasional gaps (R8)
        for (int k = 0; k < 600; k++) begin
            v = {1'b0, 8'($urandom_range(253, 0) + 1), 23'($urandom)};
            drive(v, 1'($urandom_range(1, 0)), 1'b1, 32'd0, "R1");
            if (k % 37 == 0) idle(1);
        end
        for (int k = 0; k < 300; k++) begin
            v = {9'd0, 23'($urandom)};
            if (v == 32'd0) v = 32'd1;
            drive(v, 1'b0, 1'b1, 32'd0, "R7");
            if (k % 23 == 0) idle(2);
        end
        idle(8);
        // R8: every accepted operand produced a result
        n_vec++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R8 results missing got=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule